// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

A chain of 4-bit synchronous binary counter stages, each counting modulo 16, joined into one wide counter of 4·STAGES bits. Every stage shares the clock, an active-low synchronous clear, an active-low synchronous parallel load and a parallel count enable. Stage 0 takes its trickle enable from an external pin. Each later stage takes its trickle enable from the terminal count of the stage below it. All stages therefore advance on the same clock edge, with no ripple between them.

Loading a preset and counting up to the all-ones value turns the block into a programmable divider. The final terminal count marks the last state of each cycle. It depends on the external trickle enable through a combinational path, so a further block of the same kind can be chained after this one.

Top module: `cascade_counter`

## Requirements
- R1: Each stage holds a 4-bit value that counts up from 0 to 15 and then wraps to 0. The whole 4·STAGES-bit value `q` counts as one binary number and wraps from all ones to zero.
- R2: When `clr_n` is low at a rising clock edge, `q` becomes 0, whatever `load_n`, `cnt_par`, `cnt_trk` and `din` are doing.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`, whatever the two count enables are doing.
- R4: When `clr_n` and `load_n` are both high, `q` increments by one at the rising edge if `cnt_par` and `cnt_trk` are both high.
- R5: When `clr_n` and `load_n` are both high and either count enable is low, `q` holds its value.
- R6: Bit k of `stage_tc` is high exactly when stage k's trickle enable is high and its nibble `q[4k+3:4k]` is 4'hF. `cnt_par` has no effect on it.
- R7: `stage_tc` and `tc_out` follow `cnt_trk` combinationally, with no clock edge needed in between.
- R8: Stage k (k>0) uses `stage_tc[k-1]` as its trickle enable. `tc_out` is high only when all of `q` is ones and `cnt_trk` is high.
- R9: `q` changes only at rising clock edges. Changing inputs between edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_par | input | 1 | Parallel count enable, shared by all stages |
| cnt_trk | input | 1 | Trickle count enable for stage 0 |
| din | input | 4*STAGES | Parallel preset value |
| q | output | 4*STAGES | Counter value, stage 0 in the low nibble |
| stage_tc | output | STAGES | Terminal count of each stage |
| tc_out | output | 1 | Terminal count of the last stage |

## Verification
The bench first checks priority. It clears while a load is requested and loads while both enables are high. A design with the wrong order would keep the preset, or would count past it. It then moves across nibble boundaries (0x0FF to 0x100, and the wrap from all ones to zero) and counts the full 4096-state cycle. A design whose cascade was wrong would drop a carry there, or would carry twice. The bench toggles `cnt_trk` and `cnt_par` between edges while the value is all ones. A terminal count that was registered, or one that used the parallel enable, would show the wrong level before the next edge.

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES = 3
) (
  input  logic                  clk,
  input  logic                  clr_n,
  input  logic                  load_n,
  input  logic                  cnt_par,
  input  logic                  cnt_trk,
  input  logic [4*STAGES-1:0]   din,
  output logic [4*STAGES-1:0]   q,
  output logic [STAGES-1:0]     stage_tc,
  output logic                  tc_out
);
  localparam int W = 4 * STAGES;

  logic [STAGES-1:0] trk;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      logic [3:0] nib;

      if (k == 0) begin : g_first
        assign trk[k] = cnt_trk;
      end else begin : g_next
        assign trk[k] = stage_tc[k-1];
      end

      always_ff @(posedge clk) begin
        if (!clr_n)
          nib <= 4'h0;
        else if (!load_n)
          nib <= din[4*k +: 4];
        else if (cnt_par && trk[k])
          nib <= nib + 4'h1;
      end

      assign stage_tc[k]  = trk[k] & (&nib);
      assign q[4*k +: 4]  = nib;
    end
  endgenerate

  assign tc_out = stage_tc[STAGES-1];
endmodule

module cascade_counter_chk #(
  parameter int STAGES = 3
) (
  input logic                clk,
  input logic                clr_n,
  input logic                load_n,
  input logic                cnt_par,
  input logic                cnt_trk,
  input logic [4*STAGES-1:0] din,
  input logic [4*STAGES-1:0] q,
  input logic [STAGES-1:0]   stage_tc,
  input logic                tc_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (q == '0));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> (q == $past(din)));

  // R4
  count_up_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && cnt_par && cnt_trk) |=> (q == $past(q) + 1'b1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && (!cnt_par || !cnt_trk)) |=> $stable(q));

  // R8
  final_tc_chk: assert property (@(posedge clk) disable iff (!armed)
    tc_out |-> (cnt_trk && (&q)));
endmodule

bind cascade_counter cascade_counter_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
  localparam int STAGES = 3;
  localparam int W = 4 * STAGES;

  logic clk = 1'b0;
  logic clr_n = 1'b1, load_n = 1'b1, cnt_par = 1'b0, cnt_trk = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic [STAGES-1:0] stage_tc;
  logic tc_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cascade_counter #(.STAGES(STAGES)) dut (.*);

  // {clr_n, load_n, par, trk, din, exp_q, exp_tc}
  localparam int VN = 11;
  localparam logic [28:0] VEC [VN] = '{
    {4'b0111, 12'hFFF, 12'h000, 1'b0},
    {4'b1011, 12'hABC, 12'hABC, 1'b0},
    {4'b1111, 12'h000, 12'hABD, 1'b0},
    {4'b1101, 12'h000, 12'hABD, 1'b0},
    {4'b1110, 12'h000, 12'hABD, 1'b0},
    {4'b1011, 12'h0FE, 12'h0FE, 1'b0},
    {4'b1111, 12'h000, 12'h0FF, 1'b0},
    {4'b1111, 12'h000, 12'h100, 1'b0},
    {4'b0011, 12'hFFE, 12'h000, 1'b0},
    {4'b1011, 12'hFFF, 12'hFFF, 1'b1},
    {4'b1111, 12'h000, 12'h000, 1'b0}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic p, input logic t, input logic [W-1:0] d);
    @(negedge clk);
    clr_n = c; load_n = l; cnt_par = p; cnt_trk = t; din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Table walk: R2 clear priority, R3 load priority, R4 count, R5 hold, R1 wrap, R8 carry
    for (int i = 0; i < VN; i++) begin
      step(VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24:13]);
      chk($sformatf("R2/R3/R4/R5 vec%0d q", i), q, VEC[i][12:1]);
      chk($sformatf("R8 vec%0d tc_out", i), {{(W-1){1'b0}}, tc_out}, {{(W-1){1'b0}}, VEC[i][0]});
    end

    // R6: per-stage terminal count
    step(1, 0, 0, 1, 12'h0F0);
    chk("R6 stage_tc at 0F0", {{(W-STAGES){1'b0}}, stage_tc}, 12'h000);
    step(1, 0, 0, 1, 12'h00F);
    chk("R6 stage_tc at 00F", {{(W-STAGES){1'b0}}, stage_tc}, 12'h001);

    // R7: terminal count follows trickle enable between edges; R6 par no effect
    step(1, 0, 0, 1, 12'hFFF);
    @(negedge clk);
    load_n = 1; cnt_par = 0; cnt_trk = 0; #1;
    chk("R7 tc_out trk low", {{(W-1){1'b0}}, tc_out}, '0);
    chk("R7 stage_tc trk low", {{(W-STAGES){1'b0}}, stage_tc}, '0);
    cnt_trk = 1; #1;
    chk("R7 tc_out trk high", {{(W-1){1'b0}}, tc_out}, 1);
    chk("R6 stage_tc par low", {{(W-STAGES){1'b0}}, stage_tc}, 12'h007);

    // R9: mid-cycle input changes do not move q
    #2 clr_n = 0; load_n = 0; din = 12'h123; #3;
    chk("R9 q stable between edges", q, 12'hFFF);
    clr_n = 1; load_n = 1;

    // R1/R8: full cycle of the wide counter, one tc_out pulse per wrap
    step(0, 1, 0, 0, '0);
    begin
      int tc_seen = 0;
      for (int n = 1; n <= 4096; n++) begin
        step(1, 1, 1, 1, '0);
        if (q !== n[W-1:0]) chk("R1 full-cycle count", q, n[W-1:0]);
        if (tc_out) tc_seen++;
      end
      chk("R1 wrap to zero after 4096", q, 12'h000);
      chk("R8 tc_out pulses once per cycle", tc_seen[W-1:0], 12'h001);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule